// File: doc/BRIEF.md
# Sequenced Output Port with Strobe

This block sits between a compute engine and the pins of a controller. It presents up to four 8-bit result variables one at a time. Each value appears with a 2-bit tag that names the variable and with a data strobe that marks the value as valid. The engine hands over each result through a valid/ready pair. A start pulse opens an elaboration and raises busy. The number of variables is latched at that pulse. Busy falls when the strobe of the last variable ends.

A wait input lets the engine hand over the current result. While wait is active, the port keeps the value back from the bus and releases it one clock after wait goes inactive. A pad enable follows the active-low output-enable input, and the data lines read zero whenever the pad is disabled. A timer produces a start-conversion pulse for an external A/D converter a fixed number of clocks after busy falls, or after the offline input falls while the port is idle. A high auto input masks this pulse. The wait, busy, strobe and start-conversion lines each have a polarity parameter.

Top module: `out_seq_port`

## Requirements
- R1: During reset busy, strobe and the start-conversion line sit at their inactive level, res_ready_o is 0, and out_tag_o and out_data_o (with oe_ni low) are 0.
- R2: A start_i pulse while not busy makes busy active from the next clock. res_ready_o is 1 only while the port waits for the next result, and that is only while busy.
- R3: With nvars_i = N-1 latched at start, the N values appear in order with tags 0, 1, ... N-1. Each shown value equals the res_data_i accepted for it.
- R4: The strobe stays active for exactly STROBE_CYC clocks per value (4 by default). Data and tag stay stable throughout, and the strobe goes inactive afterwards.
- R5: A result accepted while wait is inactive raises the strobe in the clock after the accepting edge.
- R6: A result accepted while wait is active is taken (res_ready_o drops), but the strobe stays inactive until the first edge that samples wait inactive. It rises in the clock after that edge.
- R7: bus_oe_o equals the inverse of oe_ni. While oe_ni is 1, out_data_o reads 0. While oe_ni is 0, out_data_o shows the last presented value.
- R8: Busy goes inactive on the edge that ends the strobe of the last variable. res_ready_o is 0 from then on.
- R9: After busy falls, the start-conversion line becomes active exactly ADC_DELAY clocks later (16 by default) and stays active for ADC_PULSE clocks (2 by default).
- R10: While not busy, a fall of offline_i starts the same timing. The pulse becomes active ADC_DELAY clocks after the first edge that samples offline_i low.
- R11: A new start_i during the countdown abandons it, and no pulse results from that fall.
- R12: While auto_i is 1, the start-conversion line stays inactive.
- R13: Each of wait, busy, strobe and start-conversion is active-high when its polarity parameter is 1 (the default) and active-low when it is 0.
- R14: start_i while busy is ignored: the tag sequence and busy continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens an elaboration |
| nvars_i | input | TAG_W | Number of variables minus one, latched at start |
| res_valid_i | input | 1 | Engine result valid |
| res_data_i | input | DATA_W | Engine result value |
| res_ready_o | output | 1 | Port accepts a result |
| wait_i | input | 1 | Holds presentation back (programmable polarity) |
| oe_ni | input | 1 | Output enable, active low |
| auto_i | input | 1 | Masks the start-conversion pulse |
| offline_i | input | 1 | Offline phase flag; its fall arms the timer |
| out_data_o | output | DATA_W | Presented value |
| out_tag_o | output | TAG_W | Index of the presented variable |
| bus_oe_o | output | 1 | Pad driver enable for out_data_o |
| strobe_o | output | 1 | Data strobe (programmable polarity) |
| busy_o | output | 1 | Elaboration in progress (programmable polarity) |
| adc_start_o | output | 1 | Start-conversion for an external A/D (programmable polarity) |

## Verification
A wrong sequencer state shows at the ports within one value period. Symptoms are a strobe that is too short or too long, a tag out of order, a value released during wait, or busy dropping before the last tag. A timer fault shows as a start-conversion edge that lands a clock early or late against the fall of busy or offline, or as a pulse that survives a restart. The sweep covers every variable count against several wait lengths and measures each of these edges to the exact clock.

// File: rtl/osp_pkg.sv
package osp_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_COLLECT,
    SQ_HOLD,
    SQ_SHOW
  } sq_state_e;

  typedef enum logic [1:0] {
    AT_IDLE,
    AT_DELAY,
    AT_PULSE
  } at_state_e;
endpackage

// File: rtl/pol_adapt.sv
module pol_adapt #(
  parameter bit ACT_HI = 1'b1
) (
  input  logic sig_i,
  output logic sig_o
);
  generate
    if (ACT_HI) begin : g_keep
      assign sig_o = sig_i;
    end else begin : g_flip
      assign sig_o = ~sig_i;
    end
  endgenerate
endmodule

// File: rtl/out_seq_ctrl.sv
module out_seq_ctrl
  import osp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int TAG_W      = 2,
  parameter int STROBE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TAG_W-1:0]  nvars_i,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_data_i,
  output logic              res_ready_o,
  input  logic              wait_act_i,
  output logic              busy_o,
  output logic              busy_set_o,
  output logic              busy_clr_o,
  output logic              show_o,
  output logic [DATA_W-1:0] data_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int SCW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [SCW-1:0] SC_LAST = SCW'(STROBE_CYC - 1);

  sq_state_e         state_q;
  logic [TAG_W-1:0]  idx_q, last_q, hold_tag_q, tag_q;
  logic [DATA_W-1:0] hold_q, data_q;
  logic [SCW-1:0]    scnt_q;
  logic              busy_q;
  logic              show_end;

  assign show_end = (state_q == SQ_SHOW) && (scnt_q == SC_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SQ_IDLE;
      idx_q      <= '0;
      last_q     <= '0;
      hold_tag_q <= '0;
      tag_q      <= '0;
      hold_q     <= '0;
      data_q     <= '0;
      scnt_q     <= '0;
      busy_q     <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            state_q <= SQ_COLLECT;
            idx_q   <= '0;
            last_q  <= nvars_i;
            busy_q  <= 1'b1;
          end
        end
        SQ_COLLECT: begin
          if (res_valid_i) begin
            idx_q <= idx_q + 1'b1;
            if (wait_act_i) begin
              // result taken, presentation deferred
              hold_q     <= res_data_i;
              hold_tag_q <= idx_q;
              state_q    <= SQ_HOLD;
            end else begin
              data_q  <= res_data_i;
              tag_q   <= idx_q;
              scnt_q  <= '0;
              state_q <= SQ_SHOW;
            end
          end
        end
        SQ_HOLD: begin
          if (!wait_act_i) begin
            data_q  <= hold_q;
            tag_q   <= hold_tag_q;
            scnt_q  <= '0;
            state_q <= SQ_SHOW;
          end
        end
        SQ_SHOW: begin
          if (show_end) begin
            if (tag_q == last_q) begin
              state_q <= SQ_IDLE;
              busy_q  <= 1'b0;
            end else begin
              state_q <= SQ_COLLECT;
            end
          end else begin
            scnt_q <= scnt_q + 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign res_ready_o = (state_q == SQ_COLLECT);
  assign busy_o      = busy_q;
  assign busy_set_o  = (state_q == SQ_IDLE) && start_i;
  assign busy_clr_o  = show_end && (tag_q == last_q);
  assign show_o      = (state_q == SQ_SHOW);
  assign data_o      = data_q;
  assign tag_o       = tag_q;
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import osp_pkg::*;
#(
  parameter int DELAY = 16,
  parameter int PULSE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic cancel_i,
  output logic pulse_o
);
  localparam int CMAX = (DELAY > PULSE) ? DELAY : PULSE;
  localparam int CW   = $clog2(CMAX + 1);

  at_state_e   st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= AT_IDLE;
      cnt_q <= '0;
    end else if (cancel_i) begin
      st_q  <= AT_IDLE;
      cnt_q <= '0;
    end else if (arm_i) begin
      st_q  <= AT_DELAY;
      cnt_q <= CW'(DELAY - 1);
    end else begin
      unique case (st_q)
        AT_IDLE: ;
        AT_DELAY: begin
          if (cnt_q == '0) begin
            st_q  <= AT_PULSE;
            cnt_q <= CW'(PULSE - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        AT_PULSE: begin
          if (cnt_q == '0) st_q <= AT_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= AT_IDLE;
      endcase
    end
  end

  assign pulse_o = (st_q == AT_PULSE);
endmodule

// File: rtl/out_seq_port.sv
module out_seq_port #(
  parameter int DATA_W        = 8,
  parameter int TAG_W         = 2,
  parameter int STROBE_CYC    = 4,
  parameter int ADC_DELAY     = 16,
  parameter int ADC_PULSE     = 2,
  parameter bit WAIT_ACT_HI   = 1'b1,
  parameter bit BUSY_ACT_HI   = 1'b1,
  parameter bit STROBE_ACT_HI = 1'b1,
  parameter bit ADC_ACT_HI    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TAG_W-1:0]  nvars_i,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_data_i,
  output logic              res_ready_o,
  input  logic              wait_i,
  input  logic              oe_ni,
  input  logic              auto_i,
  input  logic              offline_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic              bus_oe_o,
  output logic              strobe_o,
  output logic              busy_o,
  output logic              adc_start_o
);
  logic              wait_act, busy_act, show_act, adc_act, adc_gated;
  logic              busy_set, busy_clr, offl_q, arm;
  logic [DATA_W-1:0] shown_data;

  pol_adapt #(.ACT_HI(WAIT_ACT_HI)) u_wait_pol (.sig_i(wait_i), .sig_o(wait_act));

  out_seq_ctrl #(
    .DATA_W    (DATA_W),
    .TAG_W     (TAG_W),
    .STROBE_CYC(STROBE_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .nvars_i    (nvars_i),
    .res_valid_i(res_valid_i),
    .res_data_i (res_data_i),
    .res_ready_o(res_ready_o),
    .wait_act_i (wait_act),
    .busy_o     (busy_act),
    .busy_set_o (busy_set),
    .busy_clr_o (busy_clr),
    .show_o     (show_act),
    .data_o     (shown_data),
    .tag_o      (out_tag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) offl_q <= 1'b0;
    else         offl_q <= offline_i;
  end

  // offline fall counts only while idle
  assign arm = busy_clr | (offl_q & ~offline_i & ~busy_act);

  adc_conv_timer #(
    .DELAY(ADC_DELAY),
    .PULSE(ADC_PULSE)
  ) u_adc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm),
    .cancel_i(busy_set),
    .pulse_o (adc_act)
  );

  assign adc_gated = adc_act & ~auto_i;

  pol_adapt #(.ACT_HI(BUSY_ACT_HI))   u_busy_pol (.sig_i(busy_act),  .sig_o(busy_o));
  pol_adapt #(.ACT_HI(STROBE_ACT_HI)) u_strb_pol (.sig_i(show_act),  .sig_o(strobe_o));
  pol_adapt #(.ACT_HI(ADC_ACT_HI))    u_adc_pol  (.sig_i(adc_gated), .sig_o(adc_start_o));

  assign bus_oe_o   = ~oe_ni;
  assign out_data_o = oe_ni ? '0 : shown_data;
endmodule

// File: rtl/out_seq_port_chk.sv
module out_seq_port_chk #(
  parameter int DATA_W = 8,
  parameter int TAG_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_act,
  input logic              show_act,
  input logic              adc_act,
  input logic              wait_act,
  input logic              res_ready,
  input logic [DATA_W-1:0] shown_data,
  input logic [TAG_W-1:0]  shown_tag
);
  // R4
  show_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    show_act && $past(show_act) |-> $stable(shown_data) && $stable(shown_tag));

  // R6
  wait_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(show_act) |-> !$past(wait_act));

  // R2
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_ready |-> busy_act);

  // R8
  show_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    show_act |-> busy_act);

  // R11
  adc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_act |-> !busy_act);

  // R9
  adc_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_act) |-> !adc_act);
endmodule

bind out_seq_port out_seq_port_chk #(
  .DATA_W(DATA_W),
  .TAG_W (TAG_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_act  (busy_act),
  .show_act  (show_act),
  .adc_act   (adc_act),
  .wait_act  (wait_act),
  .res_ready (res_ready_o),
  .shown_data(shown_data),
  .shown_tag (out_tag_o)
);

// File: tb/sim_out_seq_port.sv
module sim_out_seq_port;
  localparam int CLK_PERIOD = 10;
  localparam int S = 4;
  localparam int D = 16;
  localparam int P = 2;

  logic       clk, rst_ni, start_i, res_valid_i, wait_i, oe_ni, auto_i, offline_i;
  logic [1:0] nvars_i;
  logic [7:0] res_data_i;

  logic       ready0, oe0, strobe0, busy0, adc0;
  logic [7:0] data0;
  logic [1:0] tag0;
  logic       ready1, oe1, strobe1, busy1, adc1;
  logic [7:0] data1;
  logic [1:0] tag1;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  out_seq_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .nvars_i(nvars_i),
    .res_valid_i(res_valid_i), .res_data_i(res_data_i), .res_ready_o(ready0),
    .wait_i(wait_i), .oe_ni(oe_ni), .auto_i(auto_i), .offline_i(offline_i),
    .out_data_o(data0), .out_tag_o(tag0), .bus_oe_o(oe0), .strobe_o(strobe0),
    .busy_o(busy0), .adc_start_o(adc0)
  );

  // inverted-polarity twin, R13
  out_seq_port #(
    .WAIT_ACT_HI(1'b0), .BUSY_ACT_HI(1'b0), .STROBE_ACT_HI(1'b0), .ADC_ACT_HI(1'b0)
  ) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .nvars_i(nvars_i),
    .res_valid_i(res_valid_i), .res_data_i(res_data_i), .res_ready_o(ready1),
    .wait_i(~wait_i), .oe_ni(oe_ni), .auto_i(auto_i), .offline_i(offline_i),
    .out_data_o(data1), .out_tag_o(tag1), .bus_oe_o(oe1), .strobe_o(strobe1),
    .busy_o(busy1), .adc_start_o(adc1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pol_cmp();
    chk({busy1, strobe1, adc1} == ~{busy0, strobe0, adc0}, "R13",
        {busy1, strobe1, adc1}, 3'(~{busy0, strobe0, adc0}));
    chk({data1, tag1, ready1} == {data0, tag0, ready0}, "R13",
        {data1, tag1, ready1}, {data0, tag0, ready0});
  endtask

  task automatic start_job(input int nv);
    nvars_i = 2'(nv);
    start_i = 1'b1;
    cyc();
    start_i = 1'b0;
    chk(busy0 == 1'b1, "R2", busy0, 1);
    chk(ready0 == 1'b1, "R2", ready0, 1);
  endtask

  task automatic feed(input int idx, input int dat, input int wc, input bit last, input string rtag);
    res_data_i  = 8'(dat);
    res_valid_i = 1'b1;
    wait_i      = (wc > 0);
    cyc();
    res_valid_i = 1'b0;
    if (wc > 0) begin
      for (int k = 0; k < wc; k++) begin
        chk(strobe0 == 1'b0, "R6", strobe0, 0);
        chk(ready0 == 1'b0, "R6", ready0, 0);
        if (k < wc - 1) cyc();
      end
      wait_i = 1'b0;
      cyc();
    end
    for (int k = 0; k < S; k++) begin
      chk(strobe0 == 1'b1, (k == 0 && wc == 0) ? "R5" : "R4", strobe0, 1);
      chk(data0 == 8'(dat), "R3", data0, dat);
      chk(tag0 == 2'(idx), rtag, tag0, idx);
      pol_cmp();
      cyc();
    end
    chk(strobe0 == 1'b0, "R4", strobe0, 0);
    if (last) begin
      chk(busy0 == 1'b0, "R8", busy0, 0);
      chk(ready0 == 1'b0, "R8", ready0, 0);
    end else begin
      chk(busy0 == 1'b1, "R2", busy0, 1);
      chk(ready0 == 1'b1, "R2", ready0, 1);
    end
  endtask

  // called at the negedge after the arming edge
  task automatic adc_expect(input string req);
    for (int k = 0; k < D; k++) begin
      chk(adc0 == 1'b0, req, adc0, 0);
      cyc();
    end
    for (int k = 0; k < P; k++) begin
      chk(adc0 == 1'b1, req, adc0, 1);
      pol_cmp();
      cyc();
    end
    chk(adc0 == 1'b0, req, adc0, 0);
  endtask

  task automatic adc_quiet(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      chk(adc0 == 1'b0, req, adc0, 0);
      cyc();
    end
  endtask

  function automatic int dat_of(input int run, input int idx);
    return (run * 37 + idx * 91 + 5) % 256;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int run;
    rst_ni = 1'b0; start_i = 1'b0; nvars_i = '0; res_valid_i = 1'b0; res_data_i = '0;
    wait_i = 1'b0; oe_ni = 1'b0; auto_i = 1'b0; offline_i = 1'b0;
    repeat (3) cyc();
    chk(busy0 == 1'b0 && strobe0 == 1'b0 && adc0 == 1'b0, "R1",
        {busy0, strobe0, adc0}, 0);
    chk(ready0 == 1'b0, "R1", ready0, 0);
    chk(tag0 == 2'd0 && data0 == 8'd0, "R1", {tag0, data0}, 0);
    pol_cmp();
    rst_ni = 1'b1;
    cyc();

    // sweep: every variable count against three wait lengths
    run = 0;
    for (int nv = 0; nv < 4; nv++) begin
      for (int wi = 0; wi < 3; wi++) begin
        int wc;
        wc = (wi == 0) ? 0 : ((wi == 1) ? 1 : 3);
        start_job(nv);
        for (int idx = 0; idx <= nv; idx++)
          feed(idx, dat_of(run, idx), wc, idx == nv, "R3");
        adc_expect("R9");
        run++;
      end
    end

    // R14: start while busy has no effect on the sequence
    start_job(2);
    feed(0, dat_of(run, 0), 0, 1'b0, "R3");
    start_i = 1'b1;
    cyc();
    start_i = 1'b0;
    chk(busy0 == 1'b1, "R14", busy0, 1);
    chk(ready0 == 1'b1, "R14", ready0, 1);
    feed(1, dat_of(run, 1), 0, 1'b0, "R14");
    feed(2, dat_of(run, 2), 2, 1'b1, "R14");
    run++;

    // R11: restart during the countdown
    repeat (3) begin
      chk(adc0 == 1'b0, "R11", adc0, 0);
      cyc();
    end
    start_job(1);
    adc_quiet(D + P + 4, "R11");
    feed(0, dat_of(run, 0), 0, 1'b0, "R3");
    feed(1, dat_of(run, 1), 0, 1'b1, "R3");
    adc_expect("R9");
    run++;

    // R10: offline fall while idle
    offline_i = 1'b1;
    cyc();
    cyc();
    offline_i = 1'b0;
    cyc();
    adc_expect("R10");

    // R12: auto masks the pulse
    auto_i = 1'b1;
    start_job(0);
    feed(0, dat_of(run, 0), 0, 1'b1, "R3");
    adc_quiet(D + P + 4, "R12");
    auto_i = 1'b0;

    // R7: output enable
    oe_ni = 1'b1;
    #1;
    chk(oe0 == 1'b0, "R7", oe0, 0);
    chk(data0 == 8'd0, "R7", data0, 0);
    oe_ni = 1'b0;
    #1;
    chk(oe0 == 1'b1, "R7", oe0, 1);
    chk(data0 == 8'(dat_of(run, 0)), "R7", data0, dat_of(run, 0));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule